// File: doc/BRIEF.md
# Satellite Tuner Tuning Sequencer

This block is the host-side controller that retunes a satellite downconverter tuner. Given a target frequency in kHz, two precomputed bandwidth codes (a reference-divider code and a filter code) and a start strobe, it checks the request against the tuning band, divides the frequency onto a 1011 kHz comparison grid, picks a charge-pump code from the band the frequency falls in, and issues a fixed series of short register-write transactions. It then polls the tuner's status byte until the lock flag appears or the retry budget is used up.

Bytes leave the block one at a time through a request/acknowledge interface to an external two-wire bus master. The block holds a byte on `tx_data` with `tx_req` high until the master answers with `tx_ack`. `tx_first` and `tx_last` mark the start and stop of each transaction, and `tx_read` marks a one-byte status read whose result comes back on `rx_data` with the acknowledge. A negative acknowledge aborts the whole sequence. The two bandwidth fields are rewritten only when their codes differ from the last values the tuner accepted, so a retune inside the same channel plan costs two transactions plus polling.

Top module: `sat_tune_seq`

## Requirements
- R1: The divider written is q = (f + 505) / 1011 with integer division, which rounds to the nearest grid point, and `prog_freq` becomes q * 1011 for every accepted request.
- R2: A request with f < 950000 or f >= 2175000 raises `error` and `done` in the cycle after start, issues no bytes and leaves `prog_freq` unchanged.
- R3: The charge-pump code c is 0 for f < 1250000, 1 for f < 1750000 and 2 otherwise. It is sent as bits 6:5 of the second gain byte, which is 0x0A | (c << 5).
- R4: The first transaction is the gain pair. Its first byte is 0x8A, with bit 0 set when `loop_off` is high.
- R5: The second transaction is the divider pair: {1'b0, q[14:8]} followed by q[7:0].
- R6: The pair 0xF0, {1'b0, br_code, 2'b00} is sent only when `br_code` differs from the last value whose pair was fully acknowledged. After reset that stored value is 0xFF, so the first tune always sends it.
- R7: The pair 0xC0, {1'b0, bf_code, 1'b0} is sent only when `bf_code` differs from the last fully acknowledged value (0xFF after reset). It is followed by at least `RSD_WAIT_MS*CYC_PER_MS` idle cycles and then the single-byte transaction 0xC8.
- R8: Status is polled with one-byte reads, at most `POLL_MAX` of them, with at least `POLL_GAP_MS*CYC_PER_MS` cycles between them. Polling stops at the first status byte with bit 6 set, which raises `locked`. If the budget runs out, the block ends with `locked` and `error` both low.
- R9: A negative acknowledge on any byte ends the sequence in the next cycle with `error` and `done` high and no further requests.
- R10: After reset `busy`, `done`, `locked`, `error`, `tx_req` and `prog_freq` are 0. `busy` stays high from the cycle after an accepted start through a one-cycle `done`, and a start while busy is ignored.
- R11: Write transactions flag their first byte with `tx_first` and their final byte with `tx_last`. A status read is a single byte with `tx_read`, `tx_first` and `tx_last` high and `tx_data` 0x00. Request, data and flags hold steady until `tx_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a retune with the present inputs |
| freq_khz | input | FREQ_W | Target frequency in kHz |
| br_code | input | 5 | Reference-divider bandwidth code |
| bf_code | input | 6 | Baseband filter code |
| loop_off | input | 1 | RF loop-through disabled |
| tx_req | output | 1 | Byte request to the bus master |
| tx_first | output | 1 | Byte opens a transaction |
| tx_last | output | 1 | Byte closes a transaction |
| tx_read | output | 1 | Request is a status read |
| tx_data | output | 8 | Byte to write |
| tx_ack | input | 1 | Bus master finished the byte |
| tx_nack | input | 1 | Tuner refused the byte (valid with tx_ack) |
| rx_data | input | 8 | Status byte read (valid with tx_ack) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| locked | output | 1 | Last sequence saw the lock flag |
| error | output | 1 | Last sequence was rejected or aborted |
| prog_freq | output | FREQ_W | Frequency actually programmed, in kHz |

## Verification
The assertions assume a bus master that raises `tx_ack` for exactly one cycle and only while `tx_req` is high, with `tx_nack` and `rx_data` meaningful only in that cycle. They also assume the request inputs are sampled only at an accepted start. The bench's master model follows this rule: it answers each request at the next falling edge, drops the acknowledge one cycle later, and steers negative acknowledges and lock status by byte and read index. It changes `freq_khz` and the codes only around the start pulse, except in one deliberate mid-sequence start that must be ignored.

// File: rtl/sts_pkg.sv
package sts_pkg;
   localparam int BR_W     = 5;
   localparam int BF_W     = 6;
   localparam int LOCK_BIT = 6;

   localparam logic [7:0] GAIN_HDR  = 8'h8A;
   localparam logic [7:0] RDIV_SEL  = 8'h0A;
   localparam logic [7:0] BR_HDR    = 8'hF0;
   localparam logic [7:0] BF_HDR    = 8'hC0;
   localparam logic [7:0] RSD_OFF   = 8'hC8;
   localparam logic [7:0] NO_FIELD  = 8'hFF;

   typedef enum logic [3:0] {
      ST_IDLE, ST_DIV, ST_GAIN0, ST_GAIN1, ST_DIVH, ST_DIVL,
      ST_BR0, ST_BR1, ST_BF0, ST_BF1, ST_SETTLE, ST_RSD,
      ST_POLL, ST_GAP, ST_FIN
   } seq_st_t;
endpackage

// File: rtl/sts_rdiv.sv
module sts_rdiv #(
   parameter int NUM_W     = 23,
   parameter int DEN_W     = 10,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             valid,
   output logic [NUM_W-1:0] quo
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem_w;

   if (NUM_W < 2) begin : g_chk_num
      $error("sts_rdiv: NUM_W must be at least 2");
   end

   if (ITERATIVE) begin : g_iter
      logic [DEN_W-1:0] acc;
      logic [NUM_W-1:0] sh;
      logic [CNT_W-1:0] cnt;
      logic             run;
      logic             vld;
      logic [DEN_W:0]   trial;
      logic             ge;

      assign trial = {acc, sh[NUM_W-1]};
      assign ge    = (trial >= {1'b0, den});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc <= '0;
            sh  <= '0;
            cnt <= '0;
            run <= 1'b0;
            vld <= 1'b0;
         end else begin
            vld <= 1'b0;
            if (go) begin
               sh  <= num;
               acc <= '0;
               cnt <= CNT_W'(NUM_W);
               run <= 1'b1;
            end else if (run) begin
               acc <= DEN_W'(ge ? trial - {1'b0, den} : trial);
               sh  <= {sh[NUM_W-2:0], ge};
               cnt <= cnt - 1'b1;
               if (cnt == CNT_W'(1)) begin
                  run <= 1'b0;
                  vld <= 1'b1;
               end
            end
         end
      end

      assign valid = vld;
      assign quo   = sh;
      assign rem_w = acc;
   end else begin : g_flat
      logic [NUM_W-1:0] q_r;
      logic [DEN_W-1:0] r_r;
      logic             vld;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_r <= '0;
            r_r <= '0;
            vld <= 1'b0;
         end else begin
            vld <= go;
            if (go) begin
               q_r <= num / NUM_W'(den);
               r_r <= DEN_W'(num % NUM_W'(den));
            end
         end
      end

      assign valid = vld;
      assign quo   = q_r;
      assign rem_w = r_r;
   end

   // R1: a finished division leaves a remainder below the divisor
   a_r1_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (rem_w < den));
endmodule

// File: rtl/sts_timer.sv
module sts_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] val,
   output logic          zero
);
   logic [CW-1:0] cnt;

   if (CW < 1) begin : g_chk_cw
      $error("sts_timer: CW must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= val;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R7/R8: a loaded non-zero wait is never reported as elapsed on the next cycle
   a_r7_wait_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      load && (val != '0) |=> !zero);
endmodule

// File: rtl/sat_tune_seq.sv
module sat_tune_seq
   import sts_pkg::*;
#(
   parameter int FREQ_W      = 22,
   parameter int XTAL_KHZ    = 10111,
   parameter int REF_DIV     = 10,
   parameter int F_MIN       = 950000,
   parameter int F_MAX       = 2175000,
   parameter int CP_EDGE_LO  = 1250000,
   parameter int CP_EDGE_HI  = 1750000,
   parameter int CYC_PER_MS  = 27000,
   parameter int RSD_WAIT_MS = 1,
   parameter int POLL_GAP_MS = 10,
   parameter int POLL_MAX    = 20,
   parameter bit ITER_DIV    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] freq_khz,
   input  logic [BR_W-1:0]   br_code,
   input  logic [BF_W-1:0]   bf_code,
   input  logic              loop_off,
   output logic              tx_req,
   output logic              tx_first,
   output logic              tx_last,
   output logic              tx_read,
   output logic [7:0]        tx_data,
   input  logic              tx_ack,
   input  logic              tx_nack,
   input  logic [7:0]        rx_data,
   output logic              busy,
   output logic              done,
   output logic              locked,
   output logic              error,
   output logic [FREQ_W-1:0] prog_freq
);
   localparam int FCMP     = XTAL_KHZ / REF_DIV;
   localparam int DEN_W    = $clog2(FCMP + 1);
   localparam int NUM_W    = FREQ_W + 1;
   localparam int SETTLE_N = RSD_WAIT_MS * CYC_PER_MS;
   localparam int GAP_N    = POLL_GAP_MS * CYC_PER_MS;
   localparam int LONG_N   = (GAP_N > SETTLE_N) ? GAP_N : SETTLE_N;
   localparam int TMR_W    = $clog2(LONG_N + 1);
   localparam int PC_W     = $clog2(POLL_MAX + 1);

   localparam logic [DEN_W-1:0]  FCMP_V   = DEN_W'(FCMP);
   localparam logic [NUM_W-1:0]  HALF_V   = NUM_W'(FCMP / 2);
   localparam logic [FREQ_W-1:0] FMIN_V   = FREQ_W'(F_MIN);
   localparam logic [FREQ_W-1:0] FMAX_V   = FREQ_W'(F_MAX);
   localparam logic [FREQ_W-1:0] CPLO_V   = FREQ_W'(CP_EDGE_LO);
   localparam logic [FREQ_W-1:0] CPHI_V   = FREQ_W'(CP_EDGE_HI);
   localparam logic [TMR_W-1:0]  SETTLE_V = TMR_W'(SETTLE_N);
   localparam logic [TMR_W-1:0]  GAP_V    = TMR_W'(GAP_N);
   localparam logic [PC_W-1:0]   LAST_PV  = PC_W'(POLL_MAX - 1);

   if (F_MAX + FCMP >= (1 << FREQ_W)) begin : g_chk_width
      $error("sat_tune_seq: FREQ_W too narrow for the tuning band");
   end
   if (NUM_W < 16) begin : g_chk_div
      $error("sat_tune_seq: divider field needs at least 15 quotient bits");
   end
   if (POLL_MAX < 1 || SETTLE_N < 1 || GAP_N < 1) begin : g_chk_poll
      $error("sat_tune_seq: poll budget and waits must be positive");
   end

   seq_st_t st, st_n;

   logic [BR_W-1:0]   br_l;
   logic [BF_W-1:0]   bf_l;
   logic              loop_l;
   logic [1:0]        cpc;
   logic [14:0]       quo_l;
   logic [7:0]        br_last, bf_last;
   logic [PC_W-1:0]   poll_cnt;
   logic              err_r, lock_r;

   logic              out_rng, br_chg, bf_chg;
   logic              accept, set_err, set_lock, keep_br, keep_bf, poll_inc;
   logic              div_go, div_vld;
   logic [NUM_W-1:0]  div_quo;
   logic [FREQ_W-1:0] prog_calc;
   logic              tmr_load, tmr_zero;
   logic [TMR_W-1:0]  tmr_val;
   logic [1:0]        cpc_in;
   logic              unused_rx_bits;

   assign unused_rx_bits = ^rx_data;

   assign out_rng   = (freq_khz < FMIN_V) || (freq_khz >= FMAX_V);
   assign cpc_in    = (freq_khz < CPLO_V) ? 2'd0 : (freq_khz < CPHI_V) ? 2'd1 : 2'd2;
   assign br_chg    = ({3'b000, br_l} != br_last);
   assign bf_chg    = ({2'b00, bf_l} != bf_last);
   assign prog_calc = FREQ_W'(div_quo * NUM_W'(FCMP));

   sts_rdiv #(.NUM_W(NUM_W), .DEN_W(DEN_W), .ITERATIVE(ITER_DIV)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .num   ({1'b0, freq_khz} + HALF_V),
      .den   (FCMP_V),
      .valid (div_vld),
      .quo   (div_quo)
   );

   sts_timer #(.CW(TMR_W)) i_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .val   (tmr_val),
      .zero  (tmr_zero)
   );

   // next state
   always_comb begin
      st_n     = st;
      accept   = 1'b0;
      set_err  = 1'b0;
      set_lock = 1'b0;
      keep_br  = 1'b0;
      keep_bf  = 1'b0;
      poll_inc = 1'b0;
      div_go   = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (st)
         ST_IDLE: begin
            if (start) begin
               accept = 1'b1;
               if (out_rng) begin
                  set_err = 1'b1;
                  st_n    = ST_FIN;
               end else begin
                  div_go = 1'b1;
                  st_n   = ST_DIV;
               end
            end
         end
         ST_DIV:    if (div_vld)  st_n = ST_GAIN0;
         ST_SETTLE: if (tmr_zero) st_n = ST_RSD;
         ST_GAP:    if (tmr_zero) st_n = ST_POLL;
         ST_FIN:    st_n = ST_IDLE;
         default: begin
            if (tx_ack) begin
               if (tx_nack) begin
                  set_err = 1'b1;
                  st_n    = ST_FIN;
               end else begin
                  case (st)
                     ST_GAIN0: st_n = ST_GAIN1;
                     ST_GAIN1: st_n = ST_DIVH;
                     ST_DIVH:  st_n = ST_DIVL;
                     ST_DIVL:  st_n = br_chg ? ST_BR0 : (bf_chg ? ST_BF0 : ST_POLL);
                     ST_BR0:   st_n = ST_BR1;
                     ST_BR1: begin
                        keep_br = 1'b1;
                        st_n    = bf_chg ? ST_BF0 : ST_POLL;
                     end
                     ST_BF0:   st_n = ST_BF1;
                     ST_BF1: begin
                        keep_bf  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = SETTLE_V;
                        st_n     = ST_SETTLE;
                     end
                     ST_RSD:   st_n = ST_POLL;
                     ST_POLL: begin
                        poll_inc = 1'b1;
                        if (rx_data[LOCK_BIT]) begin
                           set_lock = 1'b1;
                           st_n     = ST_FIN;
                        end else if (poll_cnt == LAST_PV) begin
                           st_n = ST_FIN;
                        end else begin
                           tmr_load = 1'b1;
                           tmr_val  = GAP_V;
                           st_n     = ST_GAP;
                        end
                     end
                     default:  st_n = ST_FIN;
                  endcase
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         br_l      <= '0;
         bf_l      <= '0;
         loop_l    <= 1'b0;
         cpc       <= 2'd0;
         quo_l     <= '0;
         prog_freq <= '0;
         br_last   <= NO_FIELD;
         bf_last   <= NO_FIELD;
         poll_cnt  <= '0;
         err_r     <= 1'b0;
         lock_r    <= 1'b0;
      end else begin
         st <= st_n;
         if (accept) begin
            br_l     <= br_code;
            bf_l     <= bf_code;
            loop_l   <= loop_off;
            cpc      <= cpc_in;
            poll_cnt <= '0;
            lock_r   <= 1'b0;
            err_r    <= set_err;
         end else begin
            if (set_err)  err_r  <= 1'b1;
            if (set_lock) lock_r <= 1'b1;
         end
         if (st == ST_DIV && div_vld) begin
            quo_l     <= div_quo[14:0];
            prog_freq <= prog_calc;
         end
         if (keep_br)  br_last  <= {3'b000, br_l};
         if (keep_bf)  bf_last  <= {2'b00, bf_l};
         if (poll_inc) poll_cnt <= poll_cnt + 1'b1;
      end
   end

   // byte presented to the bus master
   always_comb begin
      tx_req   = 1'b1;
      tx_first = 1'b0;
      tx_last  = 1'b0;
      tx_read  = 1'b0;
      tx_data  = 8'h00;
      case (st)
         ST_GAIN0: begin tx_first = 1'b1; tx_data = GAIN_HDR | {7'd0, loop_l}; end
         ST_GAIN1: begin tx_last  = 1'b1; tx_data = RDIV_SEL | {1'b0, cpc, 5'd0}; end
         ST_DIVH:  begin tx_first = 1'b1; tx_data = {1'b0, quo_l[14:8]}; end
         ST_DIVL:  begin tx_last  = 1'b1; tx_data = quo_l[7:0]; end
         ST_BR0:   begin tx_first = 1'b1; tx_data = BR_HDR; end
         ST_BR1:   begin tx_last  = 1'b1; tx_data = {1'b0, br_l, 2'b00}; end
         ST_BF0:   begin tx_first = 1'b1; tx_data = BF_HDR; end
         ST_BF1:   begin tx_last  = 1'b1; tx_data = {1'b0, bf_l, 1'b0}; end
         ST_RSD:   begin tx_first = 1'b1; tx_last = 1'b1; tx_data = RSD_OFF; end
         ST_POLL:  begin tx_first = 1'b1; tx_last = 1'b1; tx_read = 1'b1; end
         default:  tx_req = 1'b0;
      endcase
   end

   assign busy   = (st != ST_IDLE);
   assign done   = (st == ST_FIN);
   assign error  = err_r;
   assign locked = lock_r;

   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && !tx_ack |=> tx_req && $stable(tx_data) && $stable(tx_first)
                            && $stable(tx_last) && $stable(tx_read));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done && start |=> busy);

   a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && ((freq_khz < FMIN_V) || (freq_khz >= FMAX_V))
      |=> error && done && !tx_req);

   a_r9_nack_abort: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && tx_ack && tx_nack |=> error && done && !tx_req);

   a_r8_lock_stop: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && tx_read && tx_ack && !tx_nack && rx_data[LOCK_BIT]
      |=> locked && done && !error);
endmodule

// File: tb/test_sat_tune_seq.sv
module test_sat_tune_seq;
   localparam int CLK_PER  = 10;
   localparam int CPM      = 6;
   localparam int PMAX     = 20;
   localparam int GAPN     = 10 * CPM;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [21:0] freq_khz = '0;
   logic [4:0]  br_code = '0;
   logic [5:0]  bf_code = '0;
   logic        loop_off = 1'b0;
   logic        tx_req, tx_first, tx_last, tx_read;
   logic [7:0]  tx_data;
   logic        tx_ack, tx_nack;
   logic [7:0]  rx_data;
   logic        busy, done, locked, error;
   logic [21:0] prog_freq;

   always #(CLK_PER/2) clk = ~clk;

   sat_tune_seq #(.CYC_PER_MS(CPM), .POLL_MAX(PMAX)) i_sat_tune_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq_khz),
      .br_code(br_code), .bf_code(bf_code), .loop_off(loop_off),
      .tx_req(tx_req), .tx_first(tx_first), .tx_last(tx_last), .tx_read(tx_read),
      .tx_data(tx_data), .tx_ack(tx_ack), .tx_nack(tx_nack), .rx_data(rx_data),
      .busy(busy), .done(done), .locked(locked), .error(error), .prog_freq(prog_freq)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [10:0] exp_q[$];
   string       tag_q[$];
   int          m_br = 255, m_bf = 255, m_prog = 0;
   int          byte_idx = 0, read_idx = 0, nack_at = -1, lock_after = 1000;
   int          cyc = 0, last_ack = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, expv, expv);
      end
   endtask

   task automatic push(input bit r, input bit f, input bit l, input logic [7:0] d, input string t);
      exp_q.push_back({r, f, l, d});
      tag_q.push_back(t);
   endtask

   // bus master model: answers every request at the next falling edge
   initial begin
      tx_ack = 1'b0; tx_nack = 1'b0; rx_data = 8'h00;
      forever begin
         @(negedge clk);
         if (tx_ack) begin
            tx_ack = 1'b0; tx_nack = 1'b0;
         end else if (tx_req) begin
            chk(busy, "R10 request outside busy", 0, 1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2/R6/R7/R8 unexpected byte", int'({tx_read, tx_first, tx_last, tx_data}), 0);
            end else begin
               logic [10:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk({tx_read, tx_first, tx_last, tx_data} == e, t,
                   int'({tx_read, tx_first, tx_last, tx_data}), int'(e));
            end
            if (!tx_read && tx_data == 8'hC8)
               chk(cyc - last_ack >= CPM, "R7 settle wait", cyc - last_ack, CPM);
            if (tx_read && read_idx > 0)
               chk(cyc - last_ack >= GAPN, "R8 poll gap", cyc - last_ack, GAPN);
            tx_nack = (byte_idx == nack_at);
            if (tx_read) begin
               rx_data = (read_idx == lock_after) ? 8'h40 : 8'hBF;
               read_idx++;
            end
            byte_idx++;
            last_ack = cyc;
            tx_ack = 1'b1;
         end
      end
   end

   task automatic tune(input int f, input int br, input int bf, input bit lp,
                       input int lk, input int nk, input bit restart);
      bit reject, exp_lock, exp_err;
      int q, cp, br_i, bf_i, lock_i, n, nreads;
      reject = (f < 950000) || (f >= 2175000);
      exp_q.delete(); tag_q.delete();
      byte_idx = 0; read_idx = 0; nack_at = nk; lock_after = lk;
      br_i = -1; bf_i = -1; lock_i = -1;
      q = (f + 505) / 1011;
      if (!reject) begin
         cp = (f < 1250000) ? 0 : (f < 1750000) ? 1 : 2;
         push(0, 1, 0, 8'h8A | 8'(lp), "R4 gain byte");
         push(0, 0, 1, 8'h0A | 8'(cp << 5), "R3 charge pump");
         push(0, 1, 0, 8'((q >> 8) & 8'h7F), "R5 divider high");
         push(0, 0, 1, 8'(q & 8'hFF), "R1 divider low");
         if (br != m_br) begin
            push(0, 1, 0, 8'hF0, "R6 br header");
            push(0, 0, 1, 8'((br << 2) & 8'h7C), "R6 br field");
            br_i = exp_q.size() - 1;
         end
         if (bf != m_bf) begin
            push(0, 1, 0, 8'hC0, "R7 bf header");
            push(0, 0, 1, 8'((bf << 1) & 8'h7E), "R7 bf field");
            bf_i = exp_q.size() - 1;
            push(0, 1, 1, 8'hC8, "R7 reset strobe");
         end
         nreads = (lk < PMAX) ? lk + 1 : PMAX;
         for (int i = 0; i < nreads; i++) push(1, 1, 1, 8'h00, "R8/R11 status read");
         if (lk < PMAX) lock_i = exp_q.size() - 1;
         if (nk >= 0) while (exp_q.size() > nk + 1) begin
            void'(exp_q.pop_back()); void'(tag_q.pop_back());
         end
         if (br_i >= 0 && (nk < 0 || nk > br_i)) m_br = br;
         if (bf_i >= 0 && (nk < 0 || nk > bf_i)) m_bf = bf;
         m_prog = q * 1011;
      end
      exp_err  = reject || (nk >= 0);
      exp_lock = !reject && lock_i >= 0 && (nk < 0 || nk > lock_i);

      @(negedge clk);
      freq_khz = 22'(f); br_code = 5'(br); bf_code = 6'(bf); loop_off = lp; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (restart) begin
         repeat (3) @(negedge clk);
         chk(busy, "R10 busy during run", int'(busy), 1);
         freq_khz = 22'd949999; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      chk(n < 5000, "R10 done watchdog", n, 5000);
      chk(error == exp_err, reject ? "R2 reject error" : "R9 error flag", int'(error), int'(exp_err));
      chk(locked == exp_lock, "R8 locked flag", int'(locked), int'(exp_lock));
      chk(int'(prog_freq) == m_prog, "R1 programmed frequency", int'(prog_freq), m_prog);
      chk(exp_q.size() == 0, "R8/R9 missing bytes", exp_q.size(), 0);
      @(negedge clk);
      chk(!done && !busy, "R10 one-cycle done", int'({done, busy}), 0);
   endtask

   initial begin
      #(CLK_PER * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({busy, done, locked, error, tx_req} == 5'b0, "R10 reset outputs",
          int'({busy, done, locked, error, tx_req}), 0);
      chk(prog_freq == '0, "R10 reset frequency", int'(prog_freq), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !tx_req, "R10 idle after reset", int'({busy, tx_req}), 0);

      tune(1000000, 17, 40, 0, 2, -1, 0);     // first tune writes both fields
      tune(1000385, 17, 41, 1, 0, -1, 0);     // rounds up, only bf rewritten
      tune(1500000, 17, 41, 0, 1000, -1, 0);  // nothing rewritten, never locks
      tune(1249999, 12, 41, 1, 1, -1, 0);     // band edge, br only
      tune(1250000, 12, 41, 0, 0, -1, 1);     // band edge, restart ignored
      tune(1750000, 4, 10, 0, 3, -1, 0);      // top band edge
      tune(949999, 5, 5, 0, 0, -1, 0);        // below band
      tune(2175000, 5, 5, 0, 0, -1, 0);       // at upper limit
      tune(950000, 8, 20, 0, 0, -1, 0);       // lowest accepted
      tune(2174999, 8, 20, 1, 0, -1, 0);      // highest accepted
      tune(1100000, 9, 21, 0, 0, 1, 0);       // refused gain byte
      tune(1100000, 9, 21, 0, 0, -1, 0);      // both fields still rewritten
      tune(1100000, 9, 22, 0, 5, 7, 0);       // refused status read
      tune(1800000, 9, 22, 0, 0, -1, 0);      // fields kept after the refused read

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule